// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose I/O pins behind a flat 32-bit register bus. Each pin owns one configuration word. That word holds:

- an output data bit;
- a 3-bit mode that picks input, output, one of five interrupt detectors, or interrupt off;
- a stored 2-bit function code;
- an input-enable bit;
- a 3-bit group number.

Pad inputs pass through a two-flop synchroniser before anything looks at them. The bank drives the pad output value and its output enable.

Detected events land in status words at the top half of the map. Each status word covers 32 pins, and software clears bits by writing ones to them. A single interrupt line stays high while any status bit is set. Software sets a pin to an interrupt mode with input enable on and group 0. When the line goes high, it reads the status word and writes the same value back to acknowledge the events it saw.

Top module: `gpio_bank`

## Requirements
- R1: After reset every configuration field and every status bit is zero, so `irq` is 0, `pad_oe` is all zero, and reading a pin word returns only the synchronised pad level in bit 0.
- R2: The configuration word of pin n sits at byte address 4*n, and address bits 1:0 are ignored. A write stores data in bit 0, mode in bits 3:1, function in bits 6:5, input enable in bit 9 and group in bits 18:16. A read returns these fields at the same positions, with every other bit 0. Bit 0 of a read returns the pad input level after two clock edges of synchronisation rather than the stored data.
- R3: For mode 1 (output), `pad_oe` of the pin is 1. In every other mode it is 0. `pad_out` of the pin always carries the stored data bit.
- R4: Edge modes are 4 (rising), 5 (falling) and 6 (either). An edge applied to `pad_in` sets the pin's status bit on the third rising clock edge after the change. The bit then stays set until it is cleared.
- R5: Level modes are 2 (high) and 3 (low). The status bit is set on every cycle while the synchronised level is asserted. Once the level is gone, a write-1-to-clear leaves the bit at 0.
- R6: The status bit of pin p is bit p%32 of the word at byte address 0x800 + (p/32)*4. Writing a word clears exactly the bits written as 1. Status words of any nonzero group (address bits 10:6 not zero) read 0, and writes to them have no effect.
- R7: A status bit is set only when input enable is 1, the group field is 0 and the mode is 2 to 6. Modes 0, 1 and 7 raise no new events and leave bits that are already set unchanged.
- R8: When an event and a clear hit the same status bit in the same cycle, the bit stays set.
- R9: `irq` is 1 exactly when at least one status bit is set.
- R10: Pin addresses at or above 4*NPINS in the lower half of the map read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NPINS | Asynchronous pad levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| irq | output | 1 | Combined interrupt, high while any status bit is set |

## Verification
The assertions take it that a bus write lasts one cycle and that only bus writes can clear status. Because of that, an interrupt line that is high with no write in progress must still be high on the next cycle. They also take it that a pin with input enable low cannot gain a status bit, whatever its pad does.

The stimulus holds each pad level steady for several cycles, so the synchroniser delay is seen cleanly. It drives each bus access for exactly one clock and changes inputs only between edges. A behavioural model of the whole register map is compared against every output on every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [2:0] {
        MODE_IN      = 3'd0,
        MODE_OUT     = 3'd1,
        MODE_LVL_HI  = 3'd2,
        MODE_LVL_LO  = 3'd3,
        MODE_RISE    = 3'd4,
        MODE_FALL    = 3'd5,
        MODE_BOTH    = 3'd6,
        MODE_IRQ_OFF = 3'd7
    } pin_mode_e;

    typedef struct packed {
        logic [2:0] grp;
        logic       ie;
        logic [1:0] func;
        pin_mode_e  mode;
        logic       data;
    } pin_cfg_t;

    localparam int DATA_BIT  = 0;
    localparam int MODE_LSB  = 1;
    localparam int FUNC_LSB  = 5;
    localparam int IE_BIT    = 9;
    localparam int GRP_LSB   = 16;
    localparam int WORD_BITS = 32;

    function automatic logic [31:0] cfg_word(pin_cfg_t c, logic lvl);
        logic [31:0] w;
        w                      = '0;
        w[DATA_BIT]            = lvl;
        w[MODE_LSB +: 3]       = c.mode;
        w[FUNC_LSB +: 2]       = c.func;
        w[IE_BIT]              = c.ie;
        w[GRP_LSB +: 3]        = c.grp;
        return w;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta   = async_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stable;
endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
    import gpio_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_i,
    input  pin_cfg_t wcfg_i,
    input  logic     clr_i,
    input  logic     lvl_i,
    output pin_cfg_t cfg_o,
    output logic     status_o,
    output logic     out_o,
    output logic     oe_o
);
    typedef struct packed {
        pin_cfg_t cfg;
        logic     prev;
        logic     st;
    } pin_state_t;

    pin_state_t s_d, s_q;
    logic       armed;
    logic       ev;

    always_comb begin
        armed = s_q.cfg.ie && (s_q.cfg.grp == 3'd0);
        unique case (s_q.cfg.mode)
            MODE_LVL_HI: ev = lvl_i;
            MODE_LVL_LO: ev = !lvl_i;
            MODE_RISE:   ev = lvl_i && !s_q.prev;
            MODE_FALL:   ev = !lvl_i && s_q.prev;
            MODE_BOTH:   ev = lvl_i ^ s_q.prev;
            default:     ev = 1'b0;
        endcase
        ev = ev && armed;

        s_d      = s_q;
        s_d.prev = lvl_i;
        s_d.st   = ev || (s_q.st && !clr_i);
        if (wr_i) s_d.cfg = wcfg_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_o    = s_q.cfg;
    assign status_o = s_q.st;
    assign out_o    = s_q.cfg.data;
    assign oe_o     = (s_q.cfg.mode == MODE_OUT);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.st && !clr_i |=> s_q.st);
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev && clr_i |=> s_q.st);
    assert_unarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.cfg.ie && !s_q.st |=> !s_q.st);
    assert_oe_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i && (wcfg_i.mode == MODE_OUT) |=> oe_o);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int NPINS  = 64,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);
    localparam int NWORDS  = (NPINS + WORD_BITS - 1) / WORD_BITS;
    localparam int IDX_W   = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam int WIDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int REGION  = ADDR_W - 1;
    localparam int SLOT_W  = ADDR_W - 3;
    localparam logic [SLOT_W-1:0] NPINS_L = SLOT_W'(NPINS);
    localparam logic [3:0]        NW_L    = 4'(NWORDS);

    logic [NPINS-1:0]        lvl;
    logic [NWORDS*32-1:0]    st_all;
    logic [31:0]             st_w [NWORDS];
    pin_cfg_t                cfg_a [NPINS];
    pin_cfg_t                wcfg;
    logic                    pin_hit, stat_hit;
    logic [IDX_W-1:0]        pin_idx;
    logic [WIDX_W-1:0]       word_idx;
    logic                    unused_addr;

    assign unused_addr = ^bus_addr[1:0];

    gpio_sync #(.WIDTH(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (lvl)
    );

    always_comb begin
        pin_hit  = !bus_addr[REGION] && (bus_addr[REGION-1:2] < NPINS_L);
        stat_hit = bus_addr[REGION] && (bus_addr[REGION-1:6] == '0) &&
                   (bus_addr[5:2] < NW_L);
        pin_idx  = bus_addr[2 +: IDX_W];
        word_idx = bus_addr[2 +: WIDX_W];
        wcfg.data = bus_wdata[DATA_BIT];
        wcfg.mode = pin_mode_e'(bus_wdata[MODE_LSB +: 3]);
        wcfg.func = bus_wdata[FUNC_LSB +: 2];
        wcfg.ie   = bus_wdata[IE_BIT];
        wcfg.grp  = bus_wdata[GRP_LSB +: 3];
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        localparam int WRD = i / WORD_BITS;
        localparam int BIT = i % WORD_BITS;
        logic wr_i, clr_i;
        assign wr_i  = bus_we && pin_hit && (pin_idx == IDX_W'(i));
        assign clr_i = bus_we && stat_hit && (word_idx == WIDX_W'(WRD)) &&
                       bus_wdata[BIT];
        gpio_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (wr_i),
            .wcfg_i   (wcfg),
            .clr_i    (clr_i),
            .lvl_i    (lvl[i]),
            .cfg_o    (cfg_a[i]),
            .status_o (st_all[i]),
            .out_o    (pad_out[i]),
            .oe_o     (pad_oe[i])
        );
    end

    for (genvar j = NPINS; j < NWORDS * 32; j++) begin : g_pad
        assign st_all[j] = 1'b0;
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        assign st_w[w] = st_all[w*32 +: 32];
    end

    always_comb begin
        if (pin_hit)       bus_rdata = cfg_word(cfg_a[pin_idx], lvl[pin_idx]);
        else if (stat_hit) bus_rdata = st_w[word_idx];
        else               bus_rdata = '0;
    end

    assign irq = |st_all;

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !bus_we |=> irq);
endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
    localparam int NP = 64;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [11:0] addr = 0;
    logic        we = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic [NP-1:0] pad = 0;
    logic [NP-1:0] pad_out, pad_oe;
    logic        irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_bank #(.NPINS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .pad_in(pad),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

    // behavioural reference
    int m_mode[NP], m_data[NP], m_func[NP], m_ie[NP], m_grp[NP];
    bit m_s1[NP], m_s2[NP], m_pv[NP], m_st[NP];

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_st[p]) begin
                m_mode[p] = 0; m_data[p] = 0; m_func[p] = 0; m_ie[p] = 0; m_grp[p] = 0;
                m_s1[p] = 0; m_s2[p] = 0; m_pv[p] = 0; m_st[p] = 0;
            end
        end else begin
            int a;
            a = int'(addr);
            foreach (m_st[p]) begin
                bit ev, clr;
                case (m_mode[p])
                    2: ev = m_s2[p];
                    3: ev = !m_s2[p];
                    4: ev = m_s2[p] && !m_pv[p];
                    5: ev = !m_s2[p] && m_pv[p];
                    6: ev = m_s2[p] != m_pv[p];
                    default: ev = 0;
                endcase
                if (m_ie[p] == 0 || m_grp[p] != 0) ev = 0;
                clr = we && a >= 'h800 && a < 'h808 && ((a - 'h800) / 4 == p / 32)
                      && wdata[p % 32];
                m_st[p] = ev || (m_st[p] && !clr);
                m_pv[p] = m_s2[p];
                m_s2[p] = m_s1[p];
                m_s1[p] = pad[p];
                if (we && a < 'h800 && a / 4 == p) begin
                    m_data[p] = int'(wdata[0]);
                    m_mode[p] = int'(wdata[3:1]);
                    m_func[p] = int'(wdata[6:5]);
                    m_ie[p]   = int'(wdata[9]);
                    m_grp[p]  = int'(wdata[18:16]);
                end
            end
        end
    end

    function automatic logic [31:0] exp_rd();
        int a;
        logic [31:0] w;
        a = int'(addr);
        w = 0;
        if (a < 'h800) begin
            int p;
            p = a / 4;
            if (p < NP)
                w = 32'(m_s2[p]) | 32'(m_mode[p] << 1) | 32'(m_func[p] << 5) |
                    32'(m_ie[p] << 9) | 32'(m_grp[p] << 16);
        end else if (a < 'h808) begin
            for (int b = 0; b < 32; b++) w[b] = m_st[((a - 'h800) / 4) * 32 + b];
        end
        return w;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NP-1:0] eo, ee;
            bit anyst;
            anyst = 0;
            foreach (m_st[p]) begin
                eo[p] = m_data[p][0];
                ee[p] = (m_mode[p] == 1);
                anyst |= m_st[p];
            end
            chk(addr >= 12'h800 ? "R6 status read" : "R2 pin read", 64'(rdata), 64'(exp_rd()));
            chk("R9 irq", 64'(irq), 64'(anyst));
            chk("R3 pad_out", 64'(pad_out), 64'(eo));
            chk("R3 pad_oe", 64'(pad_oe), 64'(ee));
        end
    end

    task automatic step(); @(posedge clk); #2; endtask
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; we = 1; wdata = d; step(); we = 0; wdata = 0;
    endtask
    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a; #3; d = rdata; @(posedge clk); #2;
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1 reset state
        rd(12'h000, d); chk("R1 pin0 word", 64'(d), 0);
        chk("R1 irq", 64'(irq), 0);
        chk("R1 pad_oe", 64'(pad_oe), 0);
        // R2 field layout and unused bits
        wr(12'h014, 32'h8007_0265);
        rd(12'h016, d); chk("R2 fields", 64'(d), 64'h0007_0264);
        // R2 synchroniser delay
        pad[3] = 1;
        rd(12'h00C, d); chk("R2 sync 0 edges", 64'(d), 0);
        rd(12'h00C, d); chk("R2 sync 1 edge", 64'(d), 0);
        rd(12'h00C, d); chk("R2 sync 2 edges", 64'(d), 1);
        // R3 output drive
        wr(12'h01C, 32'h0000_0003);
        chk("R3 oe pin7", 64'(pad_oe[7]), 1);
        chk("R3 out pin7", 64'(pad_out[7]), 1);
        wr(12'h01C, 32'h0000_0001);
        chk("R3 oe off in input mode", 64'(pad_oe[7]), 0);
        // R4 rising edge
        wr(12'h028, 32'h0000_0208);
        pad[10] = 1; step(); step();
        chk("R4 no status before third edge", 64'(irq), 0);
        step();
        rd(12'h800, d); chk("R4 rise status", 64'(d), 64'h0000_0400);
        pad[10] = 0; repeat (4) step();
        rd(12'h800, d); chk("R4 sticky", 64'(d), 64'h0000_0400);
        // R6 write-1-to-clear, other groups ignored
        wr(12'h840, 32'hFFFF_FFFF);
        rd(12'h840, d); chk("R6 group1 reads 0", 64'(d), 0);
        rd(12'h800, d); chk("R6 group1 write ignored", 64'(d), 64'h0000_0400);
        wr(12'h800, 32'h0000_0001);
        rd(12'h800, d); chk("R6 zero bits untouched", 64'(d), 64'h0000_0400);
        wr(12'h800, 32'h0000_0400);
        rd(12'h800, d); chk("R6 cleared", 64'(d), 0);
        chk("R9 irq low", 64'(irq), 0);
        // R5 / R8 level high on pin 40
        wr(12'h0A0, 32'h0000_0204);
        pad[40] = 1; repeat (3) step();
        rd(12'h804, d); chk("R5 level status", 64'(d), 64'h0000_0100);
        chk("R9 irq high", 64'(irq), 1);
        wr(12'h804, 32'h0000_0100);
        rd(12'h804, d); chk("R8 event beats clear", 64'(d), 64'h0000_0100);
        pad[40] = 0; repeat (4) step();
        wr(12'h804, 32'h0000_0100);
        rd(12'h804, d); chk("R5 clear after level gone", 64'(d), 0);
        // falling, both, level low
        wr(12'h050, 32'h0000_020A);
        wr(12'h054, 32'h0000_020C);
        wr(12'h058, 32'h0000_0206);
        repeat (4) step();
        rd(12'h800, d); chk("R5 level low", 64'(d), 64'h0040_0000);
        pad[20] = 1; pad[21] = 1; repeat (4) step();
        rd(12'h800, d); chk("R4 both on rise, fall quiet", 64'(d), 64'h0060_0000);
        wr(12'h800, 32'h0020_0000);
        pad[20] = 0; pad[21] = 0; pad[22] = 1; repeat (4) step();
        rd(12'h800, d); chk("R4 fall and both", 64'(d), 64'h0070_0000);
        wr(12'h800, 32'h0070_0000);
        rd(12'h800, d); chk("R6 clear three", 64'(d), 0);
        // R7 gating
        wr(12'h030, 32'h0000_0008);
        wr(12'h034, 32'h0001_0208);
        pad[12] = 1; pad[13] = 1; repeat (4) step();
        rd(12'h800, d); chk("R7 ie off / group 1 no status", 64'(d), 0);
        pad[10] = 1; repeat (4) step();
        rd(12'h800, d); chk("R7 pin10 armed", 64'(d), 64'h0000_0400);
        wr(12'h028, 32'h0000_020E);
        rd(12'h800, d); chk("R7 off keeps status", 64'(d), 64'h0000_0400);
        wr(12'h800, 32'h0000_0400);
        pad[10] = 0; repeat (3) step(); pad[10] = 1; repeat (4) step();
        rd(12'h800, d); chk("R7 off no new event", 64'(d), 0);
        // R10 out-of-range pin slot
        wr(12'h100, 32'h0000_0203);
        rd(12'h100, d); chk("R10 beyond last pin", 64'(d), 0);
        chk("R10 no output enabled", 64'(pad_oe), 0);
        repeat (2) step();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule